// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder for a Host Bridge

This block holds the few configuration bytes of a host bridge that decide where accesses to the legacy area below 1 MiB go, and turns them into routing for any memory address, updated every cycle. Software writes and reads these bytes through a dword-wide, byte-enabled window over a 256-byte configuration space. The block sends each legacy access either to DRAM or to the PCI side, and can route reads and writes differently.

Thirteen segments are steered by seven attribute bytes. Segment 0 is the 64 KiB BIOS area. Segments 1 to 12 are 16 KiB expansion areas. A separate control byte governs the 128 KiB SMRAM window. That window can be opened to RAM for every access, or only for accesses made in system-management mode. A read-only byte reports the installed memory size, taken from an input.

Top module: `hb_attr_decode`

## Requirements
- R1: After reset all seven attribute bytes read as 0x00 and the SMRAM control byte (config byte 0x72, lane 2 of dword 0x1C) reads as 0x02. Every BIOS and expansion segment then routes both reads and writes to PCI, so `rd_dram` and `wr_dram` are 0.
- R2: Segment i takes its field from config byte 0x59 + ceil(i/2). Even segments use the high nibble and odd segments the low nibble. Segment 0 uses only the high nibble of 0x59, and the low nibble of 0x59 steers nothing.
- R3: Within a segment field, bit 0 enables reads and bit 1 enables writes. A 1 gives DRAM (output 1) and a 0 gives PCI (output 0).
- R4: Segment 0 spans 0xF0000–0xFFFFF. Segment i (1..12) spans 0xC0000 + (i−1)·0x4000 for 0x4000 bytes. An address with any bit at 20 or above set falls in no window.
- R5: For a non-SMM access to 0xA0000–0xBFFFF, both routes are DRAM exactly when bit 6 (open) of the SMRAM control byte is set.
- R6: For an SMM access to that window, both routes are DRAM when bit 6 or bit 3 (global enable) of the control byte is set.
- R7: A write changes only the bytes whose enable bit is set. The writable bytes are 0x59–0x5F (lanes 1–3 of dword 0x16, lanes 0–3 of dword 0x17) and 0x72. Byte 0x58 is not implemented and reads 0.
- R8: Writes to any other dword change neither the stored bytes nor the routing. Unimplemented bytes read 0.
- R9: Config byte 0x57 (lane 3 of dword 0x15) reads min(`ram_mib`/8, 255) and ignores writes.
- R10: Outside the BIOS, expansion and SMRAM windows, `legacy_hit` is 0 and both route outputs are 1. Inside them, `legacy_hit` is 1.
- R11: A configuration write takes effect at the clock edge on which it is accepted. Routing still shows the old value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index into the 256-byte config space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data, byte n in lane n |
| cfg_rdata | output | 32 | Read data for `cfg_dw` (combinational) |
| ram_mib | input | RAM_W | Installed memory size in MiB |
| mem_addr | input | ADDR_W | Memory access address |
| mem_smm | input | 1 | Access is made in system-management mode |
| legacy_hit | output | 1 | Address falls in a steered window |
| rd_dram | output | 1 | A read at this address goes to DRAM |
| wr_dram | output | 1 | A write at this address goes to DRAM |

## Verification
Directed cases set one nibble at a time. This shows whether the high-nibble/low-nibble split and the ceil(i/2) byte selection are right, and whether the unused low nibble of 0x59 stays dead. The SMRAM window is tried with every combination of the open bit, the global enable and SMM mode, which separates the two ways the window can open. Random write sequences with random byte enables and dword targets are followed by random addresses spread over 0x9C000–0xFFFFF, sometimes with high bits set. These catch wrong segment boundaries, lane-to-byte mix-ups and writes that leak into the wrong register.

// File: rtl/hb_attr_decode.sv
module hb_attr_decode #(
  parameter int ADDR_W = 32,
  parameter int RAM_W  = 16,
  parameter logic [7:0] SMR_RST = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [RAM_W-1:0]  ram_mib,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_smm,
  output logic              legacy_hit,
  output logic              rd_dram,
  output logic              wr_dram
);
  localparam int NSEG = 13;
  localparam int NATTR = 7;
  localparam logic [5:0] DW_RAM = 6'h15;
  localparam logic [5:0] DW_AT0 = 6'h16;
  localparam logic [5:0] DW_AT1 = 6'h17;
  localparam logic [5:0] DW_SMR = 6'h1C;
  localparam int OPEN_BIT = 6;
  localparam int GEN_BIT = 3;

  logic [NATTR-1:0][7:0] attr_q;
  logic [7:0] smr_q;
  logic [NSEG-1:0] seg_re, seg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr_q <= '0;
      smr_q  <= SMR_RST;
    end else if (cfg_wr) begin
      if (cfg_dw == DW_AT0)
        for (int l = 1; l < 4; l++)
          if (cfg_be[l]) attr_q[l-1] <= cfg_wdata[8*l +: 8];
      if (cfg_dw == DW_AT1)
        for (int l = 0; l < 4; l++)
          if (cfg_be[l]) attr_q[l+3] <= cfg_wdata[8*l +: 8];
      if (cfg_dw == DW_SMR && cfg_be[2]) smr_q <= cfg_wdata[23:16];
    end
  end

  logic [RAM_W-4:0] ram_units;
  logic [7:0] ram_byte;
  assign ram_units = ram_mib[RAM_W-1:3];
  assign ram_byte = (ram_units > (RAM_W-2)'(255)) ? 8'hFF : ram_units[7:0];

  always_comb begin
    case (cfg_dw)
      DW_RAM:  cfg_rdata = {ram_byte, 24'h0};
      DW_AT0:  cfg_rdata = {attr_q[2], attr_q[1], attr_q[0], 8'h00};
      DW_AT1:  cfg_rdata = {attr_q[6], attr_q[5], attr_q[4], attr_q[3]};
      DW_SMR:  cfg_rdata = {8'h00, smr_q, 16'h0000};
      default: cfg_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int BYTE = (i + 1) / 2;
    localparam int SH = (i % 2 == 0) ? 4 : 0;
    assign seg_re[i] = attr_q[BYTE][SH];
    assign seg_we[i] = attr_q[BYTE][SH+1];
  end

  logic low_mb, in_bios, in_exp, in_smr, smr_ram;
  logic [3:0] seg_idx;
  assign low_mb  = (mem_addr[ADDR_W-1:20] == '0);
  assign in_bios = low_mb && mem_addr[19:16] == 4'hF;
  assign in_exp  = low_mb && mem_addr[19:18] == 2'b11 && mem_addr[17:16] != 2'b11;
  assign in_smr  = low_mb && mem_addr[19:17] == 3'b101;
  assign seg_idx = in_bios ? 4'd0 : mem_addr[17:14] + 4'd1;
  assign smr_ram = smr_q[OPEN_BIT] | (mem_smm & smr_q[GEN_BIT]);

  assign legacy_hit = in_bios | in_exp | in_smr;
  assign rd_dram = in_smr ? smr_ram : (in_bios | in_exp) ? seg_re[seg_idx] : 1'b1;
  assign wr_dram = in_smr ? smr_ram : (in_bios | in_exp) ? seg_we[seg_idx] : 1'b1;

  p_other_dw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dw != DW_AT0 && cfg_dw != DW_AT1 && cfg_dw != DW_SMR)
      |=> ($stable(attr_q) && $stable(smr_q)));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(attr_q) && $stable(smr_q)));
  p_be_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dw == DW_SMR && !cfg_be[2]) |=> $stable(smr_q));
  p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_hit |-> (rd_dram && wr_dram));
  p_smr_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smr && smr_q[OPEN_BIT]) |-> (rd_dram && wr_dram && legacy_hit));
  p_ram_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == DW_RAM) |-> (cfg_rdata[23:0] == 24'h0));
endmodule

// File: tb/hb_attr_decode_bench.sv
module hb_attr_decode_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [5:0] cfg_dw = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [15:0] ram_mib = 16'd64;
  logic [31:0] mem_addr = 0;
  logic mem_smm = 0;
  logic legacy_hit, rd_dram, wr_dram;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_attr [7];
  logic [7:0] m_smr;

  always #2.5 clk = ~clk;

  hb_attr_decode u_hb_attr_decode (.*);

  function automatic void m_reset();
    foreach (m_attr[k]) m_attr[k] = 8'h00;
    m_smr = 8'h02;
  endfunction

  function automatic void m_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    for (int l = 0; l < 4; l++) begin
      int b = dw * 4 + l;
      if (be[l]) begin
        if (b >= 'h59 && b <= 'h5F) m_attr[b - 'h59] = d[8*l +: 8];
        if (b == 'h72) m_smr = d[8*l +: 8];
      end
    end
  endfunction

  function automatic logic [7:0] m_byte(input int b);
    int u;
    if (b >= 'h59 && b <= 'h5F) return m_attr[b - 'h59];
    if (b == 'h72) return m_smr;
    if (b == 'h57) begin u = ram_mib / 8; return (u > 255) ? 8'hFF : 8'(u); end
    return 8'h00;
  endfunction

  function automatic logic [31:0] m_rdata(input logic [5:0] dw);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[8*l +: 8] = m_byte(dw * 4 + l);
    return r;
  endfunction

  function automatic int m_seg(input logic [31:0] a);
    if (a >= 32'hF0000 && a <= 32'hFFFFF) return 0;
    if (a >= 32'hC0000 && a < 32'hF0000) return int'((a - 32'hC0000) / 32'h4000) + 1;
    return -1;
  endfunction

  function automatic bit m_in_smr(input logic [31:0] a);
    return a >= 32'hA0000 && a <= 32'hBFFFF;
  endfunction

  function automatic bit m_route(input logic [31:0] a, input bit smm, input bit wr);
    int s; logic [7:0] v; logic [3:0] nib;
    if (m_in_smr(a)) return m_smr[6] || (smm && m_smr[3]);
    s = m_seg(a);
    if (s < 0) return 1;
    v = m_attr[(s + 1) / 2];
    nib = (s % 2 == 0) ? v[7:4] : v[3:0];
    return wr ? nib[1] : nib[0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    m_write(dw, be, d);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input bit smm);
    mem_addr = a; mem_smm = smm; #1;
    check(req, {29'b0, legacy_hit, rd_dram, wr_dram},
          {29'b0, m_in_smr(a) || m_seg(a) >= 0, m_route(a, smm, 0), m_route(a, smm, 1)});
  endtask

  task automatic rd_check(input string req, input logic [5:0] dw);
    cfg_dw = dw; #1;
    check(req, cfg_rdata, m_rdata(dw));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 smram", cfg_rdata & 0, 0);
    cfg_dw = 6'h1C; #1; check("R1 smram byte", cfg_rdata, 32'h0002_0000);
    rd_check("R1 attr0", 6'h16);
    rd_check("R1 attr1", 6'h17);
    for (int s = 0; s < 13; s++) begin
      mem_addr = (s == 0) ? 32'hF8000 : 32'hC0000 + (s - 1) * 32'h4000 + 32'h100; #1;
      check("R1 seg pci", {rd_dram, wr_dram}, 2'b00);
    end
    // R2 low nibble of 0x59 is dead, high nibble drives segment 0
    cfg_write(6'h16, 4'b0010, 32'h0000_0F00);
    probe("R2 seg0 low nibble unused", 32'hF0000, 0);
    cfg_write(6'h16, 4'b0010, 32'h0000_1000);
    probe("R3 seg0 read only", 32'hFFFFF, 0);
    check("R3 seg0 rd", {rd_dram, wr_dram}, 2'b10);
    cfg_write(6'h16, 4'b0010, 32'h0000_2000);
    probe("R3 seg0 write only", 32'hF1234, 0);
    check("R3 seg0 wr", {rd_dram, wr_dram}, 2'b01);
    // R2 odd low nibble, even high nibble of 0x5A
    cfg_write(6'h16, 4'b0100, 32'h0001_0000);
    probe("R2 seg1", 32'hC3FFF, 0);
    check("R2 seg1 dram", rd_dram, 1);
    probe("R2 seg2", 32'hC4000, 0);
    check("R2 seg2 pci", rd_dram, 0);
    // R4 boundaries and upper bits
    probe("R4 last exp", 32'hEFFFF, 0);
    probe("R4 below smram", 32'h9FFFF, 0);
    check("R10 below window", {legacy_hit, rd_dram, wr_dram}, 3'b011);
    probe("R4 high bits", 32'h100F_0000, 0);
    check("R10 high bits", {legacy_hit, rd_dram, wr_dram}, 3'b011);
    // R5 R6 SMRAM combinations
    for (int c = 0; c < 8; c++) begin
      cfg_write(6'h1C, 4'b0100, {8'h00, 1'b0, c[1], 2'b00, c[0], 3'b010, 16'h0});
      probe("R5 smram normal", 32'hA0000, 0);
      probe("R6 smram smm", 32'hBFFFF, 1);
      if (c[2]) probe("R6 smm outside", 32'hF0000, 1);
    end
    cfg_write(6'h1C, 4'b0100, 32'h0008_0000);
    probe("R6 gen only smm", 32'hB0000, 1);
    check("R6 gen only smm dram", rd_dram, 1);
    probe("R5 gen only normal", 32'hB0000, 0);
    check("R5 gen only normal pci", rd_dram, 0);
    // R7 byte enables
    cfg_write(6'h16, 4'b0001, 32'hFFFF_FFFF);
    rd_check("R7 byte 0x58 unimplemented", 6'h16);
    cfg_write(6'h1C, 4'b1011, 32'hFFFF_FFFF);
    rd_check("R7 smram masked", 6'h1C);
    // R8 other dwords
    cfg_write(6'h10, 4'hF, 32'hFFFF_FFFF);
    rd_check("R8 unmapped read", 6'h10);
    rd_check("R8 attr unchanged", 6'h16);
    probe("R8 decode unchanged", 32'hF0000, 0);
    // R9 ram size
    ram_mib = 16'd64; rd_check("R9 ram 64", 6'h15);
    check("R9 ram 64 val", cfg_rdata, 32'h0800_0000);
    ram_mib = 16'd4000; rd_check("R9 ram sat", 6'h15);
    check("R9 ram sat val", cfg_rdata, 32'hFF00_0000);
    cfg_write(6'h15, 4'hF, 32'h1234_5678);
    rd_check("R9 ram ignores write", 6'h15);
    // R11 timing of a write
    mem_addr = 32'hD0000; mem_smm = 0;
    @(negedge clk);
    cfg_wr = 1; cfg_dw = 6'h17; cfg_be = 4'b0001; cfg_wdata = 32'h0000_0003;
    #1; check("R11 before edge", rd_dram, m_route(32'hD0000, 0, 0));
    @(negedge clk); cfg_wr = 0; m_write(6'h17, 4'b0001, 32'h3);
    #1; check("R11 after edge", {rd_dram, wr_dram}, 2'b11);
    // random
    for (int it = 0; it < 400; it++) begin
      logic [5:0] dw;
      case ($urandom % 5)
        0: dw = 6'h16; 1: dw = 6'h17; 2: dw = 6'h1C; 3: dw = 6'h15;
        default: dw = 6'($urandom);
      endcase
      cfg_write(dw, 4'($urandom), $urandom);
      rd_check("R7 random read", dw);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        a = 32'h9C000 + ($urandom % 32'h64000);
        if ($urandom % 10 == 0) a[20 + $urandom % 12] = 1'b1;
        probe("R2 R3 R4 R5 R6 random route", a, 1'($urandom));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule